// File: doc/BRIEF.md
# Galloping Pattern Memory Self-Test Controller

This controller runs a galloping-pattern check on a small RAM of `N` words through a single synchronous read/write port. It first fills the memory with a background word. It then takes each address in turn as the base cell and inverts it. Against that inverted base it reads every other cell, with a read of the base between each one, and afterwards it restores the base. The whole procedure runs once with an all-zeros background and once with an all-ones background. Every read is compared with the value that a fault-free memory would return.

The operation count grows with the square of the depth (4·N² + 2·N port cycles), so the block is meant for characterisation of small arrays, not for production screening. Software or a test sequencer pulses `start` and waits for the one-cycle `done` pulse. It then reads the sticky `fail` flag and the location of the first miscompare: the base address, the address of the other cell, and whether the base read or the other read was wrong. The RAM sits outside the block and returns read data one cycle after the request.

Top module: `galpat_tester`

## Requirements
- R1: After `start` is accepted, the block writes the background word to every address, in ascending order, one write per cycle. The first pass uses all-zeros (every bit 0).
- R2: For each base address, the block writes the complement of the background to the base. It then issues a base read followed by an other-cell read for each other address. Last, it writes the background back to the base. Base addresses run in ascending order.
- R3: Other-cell addresses run in ascending order and exclude the base address. No port cycle is spent on the skipped index.
- R4: When the all-zeros pass is complete, the whole sequence (R1 and R2) repeats once with the all-ones background (every bit 1).
- R5: A base read expects the complement of the background and an other-cell read expects the background. The read data is compared in the cycle after the read request.
- R6: The first miscompare sets `fail` and records `fail_base`, `fail_other` and `fail_on_base` (1 = the base read was wrong, 0 = the other read was wrong). Later miscompares leave the record unchanged, and an accepted `start` clears it.
- R7: `busy` is high while the test runs. `done` goes high for exactly one cycle, 4·N²+2·N cycles after the clock edge that accepts `start`. At that point `fail` and the record reflect every read.
- R8: A `start` that arrives while `busy` is high has no effect on the access sequence or the result.
- R9: After reset, `busy`, `done`, `fail` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; taken only when idle |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle pulse at the end of both passes |
| fail | output | 1 | Sticky: at least one miscompare seen |
| fail_base | output | ADDR_W | Base address at the first miscompare |
| fail_other | output | ADDR_W | Other-cell address at the first miscompare |
| fail_on_base | output | 1 | First miscompare was on the base read |
| mem_en | output | 1 | RAM access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after a read |

## Verification
A wrong loop counter or phase shows up at the RAM port in the very cycle it goes wrong: a stray address, a write in place of a read, or the base index visited as an other cell. So the bench compares every access against an independently generated sequence, cycle by cycle. A wrong expected value or a slip in the capture pipeline shows up only at `done`, as a wrong first-failure record. For that reason the bench injects a stuck bit and an inversion coupling into its RAM model, and it predicts the first miscompare by replaying the same sequence on a shadow copy. A wrong termination count shows up as a misplaced `done` pulse, which is checked against 4·N²+2·N.

// File: rtl/galpat_pkg.sv
package galpat_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FILL,
    PH_INV,
    PH_RDB,
    PH_RDO,
    PH_RST
  } phase_e;

  // First other-cell index for a given base
  function automatic int first_other(input int base);
    return (base == 0) ? 1 : 0;
  endfunction

  // Final other-cell index for a given base in an n-deep array
  function automatic int last_other(input int base, input int n);
    return (base == n - 1) ? n - 2 : n - 1;
  endfunction

  // Successor of an other-cell index, jumping over the base
  function automatic int next_other(input int oth, input int base);
    return (oth + 1 == base) ? oth + 2 : oth + 1;
  endfunction

  // Port cycles from accepted start to done
  function automatic int run_cycles(input int n);
    return 4 * n * n + 2 * n;
  endfunction

endpackage

// File: rtl/galpat_seq.sv
module galpat_seq
  import galpat_pkg::*;
#(
  parameter int N      = 8,
  parameter int DATA_W = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              start_acc,
  output logic              busy,
  output logic              done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rd_valid,
  output logic              rd_is_base,
  output logic [DATA_W-1:0] rd_exp,
  output logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] oth_addr,
  output logic [DATA_W-1:0] bg_word,
  output logic              ev_fill_wr,
  output logic              ev_inv_wr,
  output logic              ev_base_rd,
  output logic              ev_oth_rd,
  output logic              ev_rst_wr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N - 1);

  phase_e            phase_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] oth_q;
  logic              bg_q;
  logic              done_q;

  logic              oth_last;
  logic [ADDR_W-1:0] oth_first;
  logic [ADDR_W-1:0] oth_succ;

  assign bg_word   = {DATA_W{bg_q}};
  assign busy      = (phase_q != PH_IDLE);
  assign start_acc = start && (phase_q == PH_IDLE);
  assign done      = done_q;
  assign base_addr = base_q;
  assign oth_addr  = oth_q;

  assign oth_first = ADDR_W'(first_other(int'(base_q)));
  assign oth_succ  = ADDR_W'(next_other(int'(oth_q), int'(base_q)));
  assign oth_last  = (oth_q == ADDR_W'(last_other(int'(base_q), N)));

  assign ev_fill_wr = (phase_q == PH_FILL);
  assign ev_inv_wr  = (phase_q == PH_INV);
  assign ev_base_rd = (phase_q == PH_RDB);
  assign ev_oth_rd  = (phase_q == PH_RDO);
  assign ev_rst_wr  = (phase_q == PH_RST);

  always_comb begin
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = '0;
    rd_valid   = 1'b0;
    rd_is_base = 1'b0;
    rd_exp     = '0;
    unique case (phase_q)
      PH_FILL: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = oth_q;
        mem_wdata = bg_word;
      end
      PH_INV: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q;
        mem_wdata = ~bg_word;
      end
      PH_RDB: begin
        mem_en     = 1'b1;
        mem_addr   = base_q;
        rd_valid   = 1'b1;
        rd_is_base = 1'b1;
        rd_exp     = ~bg_word;
      end
      PH_RDO: begin
        mem_en   = 1'b1;
        mem_addr = oth_q;
        rd_valid = 1'b1;
        rd_exp   = bg_word;
      end
      PH_RST: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base_q;
        mem_wdata = bg_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      base_q  <= '0;
      oth_q   <= '0;
      bg_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_FILL;
            bg_q    <= 1'b0;
            oth_q   <= '0;
            base_q  <= '0;
          end
        end
        PH_FILL: begin
          if (oth_q == LAST_ADDR) begin
            phase_q <= PH_INV;
            base_q  <= '0;
          end else begin
            oth_q <= oth_q + 1'b1;
          end
        end
        PH_INV: begin
          phase_q <= PH_RDB;
          oth_q   <= oth_first;
        end
        PH_RDB: phase_q <= PH_RDO;
        PH_RDO: begin
          if (oth_last) begin
            phase_q <= PH_RST;
          end else begin
            phase_q <= PH_RDB;
            oth_q   <= oth_succ;
          end
        end
        PH_RST: begin
          if (base_q == LAST_ADDR) begin
            if (bg_q) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              phase_q <= PH_FILL;
              bg_q    <= 1'b1;
              oth_q   <= '0;
            end
          end else begin
            phase_q <= PH_INV;
            base_q  <= base_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/galpat_cmp.sv
module galpat_cmp #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rd_valid,
  input  logic              rd_is_base,
  input  logic [DATA_W-1:0] rd_exp,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] oth_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mismatch,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_base,
  output logic [ADDR_W-1:0] fail_other,
  output logic              fail_on_base
);

  logic              pend_v;
  logic              pend_isb;
  logic [DATA_W-1:0] pend_exp;
  logic [ADDR_W-1:0] pend_base;
  logic [ADDR_W-1:0] pend_oth;

  assign mismatch = pend_v && (mem_rdata != pend_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_isb  <= 1'b0;
      pend_exp  <= '0;
      pend_base <= '0;
      pend_oth  <= '0;
    end else begin
      pend_v    <= rd_valid;
      pend_isb  <= rd_is_base;
      pend_exp  <= rd_exp;
      pend_base <= base_addr;
      pend_oth  <= oth_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail         <= 1'b0;
      fail_base    <= '0;
      fail_other   <= '0;
      fail_on_base <= 1'b0;
    end else if (clear) begin
      fail         <= 1'b0;
      fail_base    <= '0;
      fail_other   <= '0;
      fail_on_base <= 1'b0;
    end else if (mismatch && !fail) begin
      fail         <= 1'b1;
      fail_base    <= pend_base;
      fail_other   <= pend_oth;
      fail_on_base <= pend_isb;
    end
  end

endmodule

// File: rtl/galpat_tester.sv
module galpat_tester
  import galpat_pkg::*;
#(
  parameter int N      = 8,
  parameter int DATA_W = 4,
  localparam int ADDR_W = (N < 2) ? 1 : $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_base,
  output logic [ADDR_W-1:0] fail_other,
  output logic              fail_on_base,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  if (N < 2) begin : g_bad_depth
    $error("galpat_tester needs N >= 2");
  end

  logic              start_acc;
  logic              rd_valid;
  logic              rd_is_base;
  logic [DATA_W-1:0] rd_exp;
  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] oth_addr;
  logic [DATA_W-1:0] bg_word;
  logic              ev_fill_wr;
  logic              ev_inv_wr;
  logic              ev_base_rd;
  logic              ev_oth_rd;
  logic              ev_rst_wr;
  logic              mismatch;

  galpat_seq #(
    .N     (N),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_acc (start_acc),
    .busy      (busy),
    .done      (done),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rd_valid  (rd_valid),
    .rd_is_base(rd_is_base),
    .rd_exp    (rd_exp),
    .base_addr (base_addr),
    .oth_addr  (oth_addr),
    .bg_word   (bg_word),
    .ev_fill_wr(ev_fill_wr),
    .ev_inv_wr (ev_inv_wr),
    .ev_base_rd(ev_base_rd),
    .ev_oth_rd (ev_oth_rd),
    .ev_rst_wr (ev_rst_wr)
  );

  galpat_cmp #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start_acc),
    .rd_valid    (rd_valid),
    .rd_is_base  (rd_is_base),
    .rd_exp      (rd_exp),
    .base_addr   (base_addr),
    .oth_addr    (oth_addr),
    .mem_rdata   (mem_rdata),
    .mismatch    (mismatch),
    .fail        (fail),
    .fail_base   (fail_base),
    .fail_other  (fail_other),
    .fail_on_base(fail_on_base)
  );

endmodule

// File: rtl/galpat_tester_sva.sv
module galpat_tester_sva #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] base_addr,
  input logic [DATA_W-1:0] bg_word,
  input logic              ev_fill_wr,
  input logic              ev_inv_wr,
  input logic              ev_base_rd,
  input logic              ev_oth_rd,
  input logic              ev_rst_wr
);

  AST_ONE_OP_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_fill_wr, ev_inv_wr, ev_base_rd, ev_oth_rd, ev_rst_wr})); // R1

  AST_FILL_WRITES_BG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_wr |-> (mem_en && mem_we && mem_wdata == bg_word)); // R1

  AST_INV_THEN_BASE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv_wr |=> (ev_base_rd && mem_addr == $past(mem_addr))); // R2

  AST_BASE_READ_THEN_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    ev_base_rd |=> ev_oth_rd); // R2

  AST_INV_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv_wr |-> (mem_we && mem_wdata == ~bg_word)); // R2

  AST_OTHER_NOT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_oth_rd |-> (!mem_we && mem_addr != base_addr)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en); // R9

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail) |-> $past(start && !busy)); // R6

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ev_rst_wr) |=> busy); // R8

endmodule

bind galpat_tester galpat_tester_sva #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .base_addr (base_addr),
  .bg_word   (bg_word),
  .ev_fill_wr(ev_fill_wr),
  .ev_inv_wr (ev_inv_wr),
  .ev_base_rd(ev_base_rd),
  .ev_oth_rd (ev_oth_rd),
  .ev_rst_wr (ev_rst_wr)
);

// File: tb/galpat_tester_tb.sv
module galpat_tester_tb;

  localparam int N  = 8;
  localparam int DW = 4;
  localparam int AW = $clog2(N);
  localparam int T  = 4 * N * N + 2 * N;

  localparam int SA_ADDR = 3;
  localparam int AGG     = 2;
  localparam int VIC     = 5;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } op_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, fail, fail_on_base;
  logic [AW-1:0] fail_base, fail_other;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  logic [DW-1:0] dut_mem [N];
  logic [DW-1:0] ref_mem [N];
  int            fault_sel = 0;

  op_t   q[$];
  string tq[$];
  int    checks = 0;
  int    errors = 0;
  logic          x_fail, x_onb;
  logic [AW-1:0] x_base, x_oth;

  always #4 clk = ~clk;

  galpat_tester #(.N(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .fail_base(fail_base), .fail_other(fail_other),
    .fail_on_base(fail_on_base), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] stored(int a, logic [DW-1:0] d);
    if (fault_sel == 1 && a == SA_ADDR) return d | DW'(1);
    return d;
  endfunction

  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      logic [DW-1:0] nv;
      nv = stored(int'(mem_addr), mem_wdata);
      if (fault_sel == 2 && int'(mem_addr) == AGG && nv != dut_mem[mem_addr])
        dut_mem[VIC] = ~dut_mem[VIC];
      dut_mem[mem_addr] = nv;
    end else if (mem_en) begin
      mem_rdata <= dut_mem[mem_addr];
    end
  end

  task automatic ref_wr(int a, logic [DW-1:0] d, string tag);
    logic [DW-1:0] nv;
    q.push_back('{we: 1'b1, a: AW'(a), d: d});
    tq.push_back(tag);
    nv = stored(a, d);
    if (fault_sel == 2 && a == AGG && nv != ref_mem[a]) ref_mem[VIC] = ~ref_mem[VIC];
    ref_mem[a] = nv;
  endtask

  task automatic ref_rd(int a, logic [DW-1:0] e, int b, int o, logic isb, string tag);
    q.push_back('{we: 1'b0, a: AW'(a), d: e});
    tq.push_back(tag);
    if (!x_fail && ref_mem[a] != e) begin
      x_fail = 1'b1; x_base = AW'(b); x_oth = AW'(o); x_onb = isb;
    end
  endtask

  task automatic build();
    q.delete(); tq.delete();
    x_fail = 1'b0; x_base = '0; x_oth = '0; x_onb = 1'b0;
    for (int i = 0; i < N; i++) ref_mem[i] = '0;
    for (int p = 0; p < 2; p++) begin
      logic [DW-1:0] bgw;
      bgw = (p == 0) ? '0 : '1;
      for (int a = 0; a < N; a++) ref_wr(a, bgw, (p == 0) ? "R1" : "R4");
      for (int b = 0; b < N; b++) begin
        ref_wr(b, ~bgw, "R2");
        for (int o = 0; o < N; o++) begin
          if (o != b) begin
            ref_rd(b, ~bgw, b, o, 1'b1, "R2");
            ref_rd(o, bgw, b, o, 1'b0, "R3");
          end
        end
        ref_wr(b, bgw, "R2");
      end
    end
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(int fault, bit mid_start);
    bit seen_done;
    fault_sel = fault;
    for (int i = 0; i < N; i++) dut_mem[i] = '0;
    build();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen_done = 1'b0;
    check(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
    for (int k = 0; k < 4 * T; k++) begin
      if (done) begin
        check(k == T, "R7", "done cycle", k, T);
        check(busy == 1'b0, "R7", "busy at done", int'(busy), 0);
        seen_done = 1'b1;
        break;
      end
      if (mem_en) begin
        if (q.size() == 0) begin
          check(1'b0, "R1", "access beyond sequence", int'(mem_addr), 0);
        end else begin
          op_t e;
          string tg;
          e = q.pop_front();
          tg = tq.pop_front();
          check(mem_we == e.we && mem_addr == e.a && (!e.we || mem_wdata == e.d),
                tg, "access", int'({mem_we, mem_addr, mem_wdata}),
                int'({e.we, e.a, e.we ? e.d : mem_wdata}));
        end
      end
      if (mid_start && k == 40) start = 1'b1;
      if (k == 41) start = 1'b0;
      @(negedge clk);
    end
    if (!seen_done) check(1'b0, "R7", "watchdog, no done", 0, 1);
    check(q.size() == 0, "R8", "sequence length left", q.size(), 0);
    check(fail == x_fail, "R5", "fail flag", int'(fail), int'(x_fail));
    if (x_fail) begin
      check(fail_base == x_base, "R6", "fail_base", int'(fail_base), int'(x_base));
      check(fail_other == x_oth, "R6", "fail_other", int'(fail_other), int'(x_oth));
      check(fail_on_base == x_onb, "R6", "fail_on_base", int'(fail_on_base), int'(x_onb));
    end
    @(negedge clk);
    check(done == 1'b0, "R7", "done one cycle", int'(done), 0);
    check(mem_en == 1'b0, "R9", "idle port quiet", int'(mem_en), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && fail == 0 && mem_en == 0, "R9", "reset state",
          int'({busy, done, fail, mem_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && mem_en == 0, "R9", "idle after reset", int'({busy, mem_en}), 0);
    run(0, 1'b0);
    run(1, 1'b1);
    run(2, 1'b0);
    run(0, 1'b0);
    check(fail == 1'b0, "R6", "fail cleared by new start", int'(fail), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule